// File: doc/BRIEF.md
# Packed Decimal / Binary Integer Converter

This block translates between a ten-byte signed packed-decimal operand and a 64-bit two's-complement integer, in either direction, over several clock cycles. The decimal operand keeps eighteen digits in its nine low bytes. Each byte holds two digits, and the byte with the larger index carries the more significant pair. The top byte holds only a sign flag.

One start pulse, qualified by a direction select, launches a conversion. The block then handles one byte, which is two digits, on each clock. In decimal-to-binary mode it walks from the most significant digit pair down, folding each pair into a running total. In binary-to-decimal mode it peels two digits off the magnitude each cycle, least significant pair first. It reports a magnitude too large for eighteen digits.

The block does not check digit nibbles for legality. It does no floating-point work.

Top module: `bcd_bin_conv`

## Requirements
- R1: In decode mode (dir = 0) the result on bin_out is the value of the eighteen digits of bcd_in. Digit j (j = 0 is least significant) sits in bits [4j+3:4j], so each byte k holds its tens digit in bits [8k+7:8k+4] and its units digit in bits [8k+3:8k].
- R2: In decode mode, bit 79 of bcd_in set makes bin_out the two's-complement negation of the digit value. Bits 78..72 have no effect, and a set bit 79 with all digits zero gives zero.
- R3: In encode mode (dir = 1) bcd_out bits 79..72 become 8'h80 when bin_in is negative and 8'h00 otherwise. This value is in place from the cycle after start is accepted.
- R4: In encode mode bcd_out bits 71..0 hold the decimal digits of the magnitude of bin_in, laid out as in R1, with the least significant pair produced first.
- R5: In encode mode, every digit above the most significant nonzero digit of the magnitude reads as zero.
- R6: In encode mode ovf is set at completion if the magnitude is 10^18 or larger, and the digits then hold the magnitude modulo 10^18. ovf is cleared by every accepted start and stays 0 after a decode.
- R7: After start is accepted while idle, busy is high for exactly nine cycles, one per digit byte. done is then high for exactly one cycle with busy low, and the results are valid from that cycle on.
- R8: start asserted while busy is ignored. Neither the operands nor dir presented at that time affect the conversion in progress or its result.
- R9: A decode leaves bcd_out unchanged, and an encode leaves bin_out unchanged. Each output holds its value until a later conversion of its own kind completes.
- R10: Synchronous active-high reset clears busy, done, ovf, bin_out and bcd_out to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, taken only when idle |
| dir | input | 1 | 0 = decimal to binary, 1 = binary to decimal |
| bcd_in | input | 80 | Packed-decimal operand for decode |
| bin_in | input | 64 | Signed integer operand for encode |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| bin_out | output | 64 | Decode result |
| bcd_out | output | 80 | Encode result |
| ovf | output | 1 | Encode magnitude exceeded eighteen digits |

## Verification
The sweep covers every digit count from zero to eighteen in both directions. It uses random magnitudes and the all-nines value at each length. A design that reversed the byte walk, or swapped tens and units, would produce wrong values at every length beyond one.

The bench also targets these corner cases:
- A set sign bit on an all-zero operand, which must decode to zero.
- Sign bytes with stray low bits, which must not change the result.
- The most negative integer, whose magnitude only fits as an unsigned value.
- Magnitudes exactly at and just below 10^18. An off-by-one overflow test or a mishandled sign would show up here.
- Starts injected mid-conversion with flipped operands and direction. A design that restarted or re-sampled would return corrupted results or a wrong busy count.

// File: rtl/bcdc_pkg.sv
package bcdc_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic {
        DIR_DECODE = 1'b0,
        DIR_ENCODE = 1'b1
    } conv_dir_e;

    typedef struct packed {
        logic [3:0] tens;
        logic [3:0] units;
    } digit_pair_t;

    // Numeric value of one packed digit pair (0..99 for legal digits).
    function automatic logic [7:0] pair_value(digit_pair_t p);
        return 8'(p.tens) * 8'd10 + 8'(p.units);
    endfunction

    // Split a value 0..99 into its two decimal digits.
    function automatic digit_pair_t pair_pack(logic [6:0] v);
        digit_pair_t p;
        p.tens  = 4'(v / 7'd10);
        p.units = 4'(v % 7'd10);
        return p;
    endfunction

endpackage

// File: rtl/bcdc_dec_step.sv
module bcdc_dec_step
    import bcdc_pkg::*;
#(
    parameter int BIN_W = 64
) (
    input  logic [BIN_W-1:0] acc_i,
    input  digit_pair_t      pair_i,
    output logic [BIN_W-1:0] acc_o
);

    // Fold one more digit pair into the running total.
    always_comb begin
        acc_o = acc_i * BIN_W'(100) + BIN_W'(pair_value(pair_i));
    end

endmodule

// File: rtl/bcdc_enc_step.sv
module bcdc_enc_step
    import bcdc_pkg::*;
#(
    parameter int BIN_W = 64
) (
    input  logic [BIN_W-1:0] rem_i,
    output logic [BIN_W-1:0] rem_o,
    output digit_pair_t      pair_o
);

    logic [6:0] low_two;

    // Strip the two least significant decimal digits.
    always_comb begin
        low_two = 7'(rem_i % BIN_W'(100));
        rem_o   = rem_i / BIN_W'(100);
        pair_o  = pair_pack(low_two);
    end

endmodule

// File: rtl/bcdc_seq.sv
module bcdc_seq #(
    parameter int STEPS = 9
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic accept,
    output logic busy,
    output logic last,
    output logic done
);

    localparam int IDX_W = (STEPS > 1) ? $clog2(STEPS) : 1;

    logic [IDX_W-1:0] idx_q;

    assign accept = start && !busy;
    assign last   = busy && (idx_q == IDX_W'(STEPS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            idx_q <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy  <= 1'b1;
                idx_q <= '0;
            end else if (busy) begin
                if (last) begin
                    busy  <= 1'b0;
                    done  <= 1'b1;
                    idx_q <= '0;
                end else begin
                    idx_q <= idx_q + IDX_W'(1);
                end
            end
        end
    end

    // R7: one step per cycle while working
    a_r7_step_advance: assert property (@(posedge clk) disable iff (rst)
        busy && !last |=> busy && (idx_q == $past(idx_q) + IDX_W'(1)));

    // R7: completion pulse follows the final step and lasts one cycle
    a_r7_done_after_last: assert property (@(posedge clk) disable iff (rst)
        last |=> done && !busy);

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: a request during a conversion does not restart it
    a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
        busy && start && !last |=> busy && (idx_q != '0));

endmodule

// File: rtl/bcd_bin_conv.sv
module bcd_bin_conv
    import bcdc_pkg::*;
#(
    parameter  int DIG_BYTES = 9,
    parameter  int BIN_W     = 64,
    localparam int DIG_W     = DIG_BYTES * BYTE_W,
    localparam int OP_W      = DIG_W + BYTE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             dir,
    input  logic [OP_W-1:0]  bcd_in,
    input  logic [BIN_W-1:0] bin_in,
    output logic             busy,
    output logic             done,
    output logic [BIN_W-1:0] bin_out,
    output logic [OP_W-1:0]  bcd_out,
    output logic             ovf
);

    logic accept, last;

    conv_dir_e        mode_q;
    logic             neg_q;
    logic [BIN_W-1:0] work_q;
    logic [DIG_W-1:0] src_q;
    logic [BIN_W-1:0] bin_out_q;
    logic [DIG_W-1:0] dig_out_q;
    logic [7:0]       sign_out_q;
    logic             ovf_q;

    logic [BIN_W-1:0] dec_acc;
    logic [BIN_W-1:0] enc_rem;
    digit_pair_t      dec_pair;
    digit_pair_t      enc_pair;
    logic             unused_sign_bits;

    assign unused_sign_bits = ^bcd_in[OP_W-2:DIG_W];

    bcdc_seq #(.STEPS(DIG_BYTES)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .accept (accept),
        .busy   (busy),
        .last   (last),
        .done   (done)
    );

    // Decode consumes the top byte of the shifting source register.
    assign dec_pair = digit_pair_t'(src_q[DIG_W-1 -: BYTE_W]);

    bcdc_dec_step #(.BIN_W(BIN_W)) u_dec (
        .acc_i  (work_q),
        .pair_i (dec_pair),
        .acc_o  (dec_acc)
    );

    bcdc_enc_step #(.BIN_W(BIN_W)) u_enc (
        .rem_i  (work_q),
        .rem_o  (enc_rem),
        .pair_o (enc_pair)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q     <= DIR_DECODE;
            neg_q      <= 1'b0;
            work_q     <= '0;
            src_q      <= '0;
            bin_out_q  <= '0;
            dig_out_q  <= '0;
            sign_out_q <= '0;
            ovf_q      <= 1'b0;
        end else if (accept) begin
            mode_q <= conv_dir_e'(dir);
            ovf_q  <= 1'b0;
            if (conv_dir_e'(dir) == DIR_ENCODE) begin
                neg_q      <= bin_in[BIN_W-1];
                work_q     <= bin_in[BIN_W-1] ? (BIN_W'(0) - bin_in) : bin_in;
                sign_out_q <= bin_in[BIN_W-1] ? 8'h80 : 8'h00;
                dig_out_q  <= '0;
            end else begin
                neg_q  <= bcd_in[OP_W-1];
                work_q <= '0;
                src_q  <= bcd_in[DIG_W-1:0];
            end
        end else if (busy) begin
            if (mode_q == DIR_DECODE) begin
                work_q <= dec_acc;
                src_q  <= src_q << BYTE_W;
                if (last) begin
                    bin_out_q <= neg_q ? (BIN_W'(0) - dec_acc) : dec_acc;
                end
            end else begin
                // New pairs enter at the top; after all steps the first
                // one produced has reached byte 0.
                work_q    <= enc_rem;
                dig_out_q <= {enc_pair, dig_out_q[DIG_W-1:BYTE_W]};
                if (last) begin
                    ovf_q <= (enc_rem != '0);
                end
            end
        end
    end

    assign bin_out = bin_out_q;
    assign bcd_out = {sign_out_q, dig_out_q};
    assign ovf     = ovf_q;

    // R3: sign byte reflects the operand sign right after acceptance
    a_r3_sign_byte: assert property (@(posedge clk) disable iff (rst)
        accept && dir |=> bcd_out[OP_W-1 -: BYTE_W] ==
                          ($past(bin_in[BIN_W-1]) ? 8'h80 : 8'h00));

    // R6: a decode never reports overflow
    a_r6_decode_no_ovf: assert property (@(posedge clk) disable iff (rst)
        accept && !dir |=> !ovf);

    // R9: each direction leaves the other direction's output alone
    a_r9_decode_keeps_bcd: assert property (@(posedge clk) disable iff (rst)
        busy && (mode_q == DIR_DECODE) |=> $stable(bcd_out));

    a_r9_encode_keeps_bin: assert property (@(posedge clk) disable iff (rst)
        busy && (mode_q == DIR_ENCODE) |=> $stable(bin_out));

    // R2: a negative decode result is zero or has its sign bit set
    a_r2_neg_result: assert property (@(posedge clk) disable iff (rst)
        done && (mode_q == DIR_DECODE) && neg_q |->
            (bin_out == '0) || bin_out[BIN_W-1]);

endmodule

// File: tb/bcd_bin_conv_tb.sv
`timescale 1ns/1ps
module bcd_bin_conv_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        dir;
    logic [79:0] bcd_in;
    logic [63:0] bin_in;
    logic        busy;
    logic        done;
    logic [63:0] bin_out;
    logic [79:0] bcd_out;
    logic        ovf;

    int          n_vec = 0;
    int          n_bad = 0;
    logic [79:0] last_bcd;
    logic [63:0] last_bin;
    logic [63:0] seed = 64'h2545_F491_4F6C_DD1D;

    always #4 clk = ~clk;

    bcd_bin_conv u_dut (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .dir     (dir),
        .bcd_in  (bcd_in),
        .bin_in  (bin_in),
        .busy    (busy),
        .done    (done),
        .bin_out (bin_out),
        .bcd_out (bcd_out),
        .ovf     (ovf)
    );

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    function automatic logic [63:0] p10(int j);
        logic [63:0] r = 64'd1;
        for (int i = 0; i < j; i++) r = r * 64'd10;
        return r;
    endfunction

    // Digit j of m placed at bits [4j+3:4j]; sign flag in byte 9.
    function automatic logic [79:0] mk_bcd(logic [63:0] m, logic s);
        logic [79:0] r = '0;
        for (int j = 0; j < 18; j++) r[4*j +: 4] = 4'((m / p10(j)) % 64'd10);
        r[79:72] = s ? 8'h80 : 8'h00;
        return r;
    endfunction

    function automatic logic [7:0] pick_top(int i);
        case (i % 5)
            0: return 8'h00;
            1: return 8'h80;
            2: return 8'hFF;
            3: return 8'h7F;
            default: return 8'h81;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [79:0] act, input logic [79:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run(input logic d, input logic [79:0] bi, input logic [63:0] ni,
                       input bit disturb, output int nbusy);
        @(negedge clk);
        dir = d; bcd_in = bi; bin_in = ni; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        nbusy = 0;
        while (!done && nbusy < 20) begin
            if (busy) nbusy++;
            if (disturb && nbusy == 3) begin
                start = 1'b1; dir = ~d; bcd_in = ~bi; bin_in = ~ni;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    task automatic dec_test(input logic [63:0] n, input logic [7:0] top, input bit disturb);
        logic [79:0] b;
        logic [63:0] e;
        int          nb;
        b = mk_bcd(n, 1'b0);
        b[79:72] = top;
        e = top[7] ? (64'd0 - n) : n;
        run(1'b0, b, ~n, disturb, nb);
        chk("R7 busy length", 80'(nb), 80'd9);
        chk("R7 done raised", 80'(done), 80'd1);
        chk(disturb ? "R8 decode under disturb" : "R1 R2 decode value", 80'(bin_out), 80'(e));
        chk("R9 bcd_out kept by decode", bcd_out, last_bcd);
        chk("R6 no ovf on decode", 80'(ovf), 80'd0);
        @(negedge clk);
        chk("R7 done single cycle", 80'(done), 80'd0);
        last_bin = e;
    endtask

    task automatic enc_test(input logic [63:0] x, input bit disturb);
        logic        s;
        logic [63:0] m;
        logic [79:0] e;
        int          nb;
        s = x[63];
        m = s ? (64'd0 - x) : x;
        e = mk_bcd(m, s);
        run(1'b1, ~e, x, disturb, nb);
        chk("R7 busy length", 80'(nb), 80'd9);
        chk("R7 done raised", 80'(done), 80'd1);
        chk(disturb ? "R8 encode under disturb" : "R3 R4 encode value", bcd_out, e);
        chk("R6 overflow flag", 80'(ovf), 80'(m >= p10(18)));
        chk("R9 bin_out kept by encode", 80'(bin_out), 80'(last_bin));
        if (m < 64'd100)
            chk("R5 upper digits zero", 80'(bcd_out[71:8]), 80'd0);
        @(negedge clk);
        chk("R7 done single cycle", 80'(done), 80'd0);
        last_bcd = e;
    endtask

    initial begin
        logic [63:0] n;
        rst = 1'b1; start = 1'b0; dir = 1'b0; bcd_in = '0; bin_in = '0;
        repeat (3) @(negedge clk);
        chk("R10 reset busy", 80'(busy), 80'd0);
        chk("R10 reset done", 80'(done), 80'd0);
        chk("R10 reset ovf", 80'(ovf), 80'd0);
        chk("R10 reset bin_out", 80'(bin_out), 80'd0);
        chk("R10 reset bcd_out", bcd_out, 80'd0);
        rst = 1'b0;
        last_bcd = '0;
        last_bin = '0;

        for (int k = 0; k <= 18; k++) begin
            for (int r = 0; r < 10; r++) begin
                seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
                n = seed % p10(k);
                if (r == 9) n = p10(k) - 64'd1;
                dec_test(n, pick_top(k + r), r == 5);
                enc_test(n, r == 6);
                enc_test(64'd0 - n, r == 7);
                enc_test(seed, 1'b0);
            end
        end

        // Boundaries: R2 negative zero, R6 overflow threshold, extreme integers
        dec_test(64'd0, 8'h80, 1'b0);
        dec_test(p10(18) - 64'd1, 8'h80, 1'b0);
        dec_test(p10(18) - 64'd1, 8'h00, 1'b0);
        enc_test(p10(18) - 64'd1, 1'b0);
        enc_test(p10(18), 1'b0);
        enc_test(64'd0 - p10(18), 1'b0);
        enc_test(64'd0 - (p10(18) - 64'd1), 1'b0);
        enc_test(64'h7FFF_FFFF_FFFF_FFFF, 1'b0);
        enc_test(64'h8000_0000_0000_0000, 1'b0);
        enc_test(64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
        enc_test(64'd0, 1'b0);
        dec_test(64'd7, 8'h7F, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule